// File: doc/BRIEF.md
# Pipelined Zero-Turnaround SRAM Controller

This block connects a pipelined request/response bus to a 32-bit synchronous SRAM of the zero-bus-turnaround kind. A requester offers one read or write per clock. Each request the controller accepts becomes one command cycle on the memory pins: a word address, active-low byte-write strobes, a write strobe and a chip select. Write data goes onto the memory data bus two cycles after its command. Read data comes back from the memory in that same slot, and the controller registers it and returns it in request order with a single-cycle valid strobe.

Reads and writes both use the same fixed two-cycle data slot, so the shared data bus never carries two words in one cycle. The controller can therefore mix reads and writes freely with no idle cycles between them. It counts reads that have been issued but not yet returned, and it stops accepting requests only when that count reaches the configured limit. The data bus is presented as separate out, in and output-enable signals, which are combined into a tri-state pad outside the block.

Top module: `zbt_sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the memory pins are idle: `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_bw_n` is 4'hF, `sram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. In the following cycle, the command cycle, `sram_addr` equals byte address bits [22:2] and `sram_cs_n` is 0.
- R3: In the command cycle of a write, `sram_we_n` is 0 and `sram_bw_n` equals the bitwise inverse of `req_be`, where bit i covers data bits 8i+7..8i. In every other cycle `sram_we_n` is 1 and `sram_bw_n` is 4'hF.
- R4: Write data is driven on `sram_dq_out`, with `sram_dq_oe` high, in exactly the cycle two clocks after that write's command cycle. `sram_dq_oe` is 0 in every other cycle.
- R5: `sram_oe_n` is 0 only in the cycle two clocks after a read's command cycle, and it is never 0 while `sram_dq_oe` is 1.
- R6: `sram_cs_n` is 0 in every command cycle and in the two cycles that follow a read's command cycle. It is 1 in all other cycles.
- R7: For each read, `rsp_valid` is high for exactly one cycle. That cycle comes right after the read's data-bus slot, three clocks after the accepting edge. `rsp_rdata` then holds the word the memory drove in that slot, and responses come out in request order. A read sees the result of every write accepted before it, including a write accepted on the previous clock.
- R8: `req_ready` stays high while fewer than MAX_OUT (default 64) reads are outstanding, so one request is accepted on every clock, in any mix of reads and writes.
- R9: A synchronous reset drops every request still in the pipeline. After reset, no `rsp_valid` pulse and no write data phase appears for a request accepted before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SRAM |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Byte address; bits [22:2] select the word |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Active-high byte enables for writes |
| rsp_valid | output | 1 | One-cycle strobe marking returned read data |
| rsp_rdata | output | 32 | Returned read data |
| sram_addr | output | 21 | Word address to the SRAM |
| sram_bw_n | output | 4 | Active-low byte-write enables |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_dq_out | output | 32 | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Enables the controller's data-bus drivers |
| sram_dq_in | input | 32 | Data received from the SRAM |

## Verification
The assertions assume that the memory reads the command on the edge after the command cycle and drives read data only while `sram_oe_n` is low in the following slot. They also assume the pad logic outside the block routes `sram_dq_out` onto the bus only while `sram_dq_oe` is high. The bench's memory model follows exactly this two-stage timing. It drives `sram_dq_in` from its array only during a proper read slot, and it writes the array only when the controller's output enable is high. Random addresses are drawn from a small window of words, spread across the high and low address bits, so that reads often hit recently written words. Directed sequences cover alternating read/write traffic, a read right after a write to the same word, a write with no byte enables, and a reset taken with reads still in flight.

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl #(
  parameter int BYTE_AW = 23,
  parameter int DW      = 32,
  parameter int MAX_OUT = 64,
  localparam int BE_W   = DW / 8,
  localparam int WA_W   = BYTE_AW - $clog2(BE_W),
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [BYTE_AW-1:0] req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic [BE_W-1:0]    req_be,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic [WA_W-1:0]    sram_addr,
  output logic [BE_W-1:0]    sram_bw_n,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic               sram_cs_n,
  output logic [DW-1:0]      sram_dq_out,
  output logic               sram_dq_oe,
  input  logic [DW-1:0]      sram_dq_in
);

  logic             s0_vld, s0_wr, s1_vld, s1_wr, s2_vld, s2_wr;
  logic [DW-1:0]    s0_wd, s1_wd, s2_wd;
  logic [CNT_W-1:0] rd_cnt;
  logic             accept, take_rd, s2_rd;
  logic             unused_lsb;

  assign accept     = req_valid & req_ready;
  assign take_rd    = accept & ~req_write;
  assign s2_rd      = s2_vld & ~s2_wr;
  assign req_ready  = rd_cnt < CNT_W'(MAX_OUT);
  assign unused_lsb = ^req_addr[BYTE_AW-WA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_vld    <= 1'b0;
      s0_wr     <= 1'b0;
      s0_wd     <= '0;
      sram_addr <= '0;
      sram_we_n <= 1'b1;
      sram_bw_n <= '1;
    end else begin
      s0_vld    <= accept;
      s0_wr     <= req_write;
      s0_wd     <= req_wdata;
      sram_addr <= accept ? req_addr[BYTE_AW-1 -: WA_W] : sram_addr;
      sram_we_n <= ~(accept & req_write);
      sram_bw_n <= (accept & req_write) ? ~req_be : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      s1_wr  <= 1'b0;
      s2_wr  <= 1'b0;
      s1_wd  <= '0;
      s2_wd  <= '0;
    end else begin
      s1_vld <= s0_vld;
      s1_wr  <= s0_wr;
      s1_wd  <= s0_wd;
      s2_vld <= s1_vld;
      s2_wr  <= s1_wr;
      s2_wd  <= s1_wd;
    end
  end

  assign sram_cs_n   = ~(s0_vld | (s1_vld & ~s1_wr) | s2_rd);
  assign sram_oe_n   = ~s2_rd;
  assign sram_dq_oe  = s2_vld & s2_wr;
  assign sram_dq_out = s2_wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rd_cnt    <= '0;
    end else begin
      rsp_valid <= s2_rd;
      if (s2_rd) rsp_rdata <= sram_dq_in;
      rd_cnt <= rd_cnt + CNT_W'(take_rd) - CNT_W'(rsp_valid);
    end
  end

endmodule

// File: rtl/zbt_sram_ctrl_chk.sv
module zbt_sram_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic sram_we_n,
  input logic sram_oe_n,
  input logic sram_cs_n,
  input logic sram_dq_oe,
  input logic rsp_valid
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid));

  a_r3_write_needs_select: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_cs_n);

  a_r4_data_two_after_write: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> ##2 sram_dq_oe);

  a_r4_drive_has_cause: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> $past(!sram_we_n, 2));

  a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n));

  a_r6_select_in_data_slot: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_cs_n);

  a_r7_response_follows_slot: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |=> rsp_valid);

  a_r7_response_has_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!sram_oe_n));

endmodule

bind zbt_sram_ctrl zbt_sram_ctrl_chk u_chk (.*);

// File: tb/tb_zbt_sram_ctrl.sv
module tb_zbt_sram_ctrl;

  typedef struct packed {
    logic        v;
    logic        wr;
    logic [20:0] a;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] ex;
  } op_t;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, sram_we_n, sram_oe_n, sram_cs_n, sram_dq_oe;
  logic [31:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [20:0] sram_addr;
  logic [3:0]  sram_bw_n;

  int  checks = 0, failures = 0;
  bit  done = 0;
  op_t h0, h1, h2, h3;
  logic [31:0] ref_mem [int];
  logic [31:0] mem [int];
  logic        m1_v, m1_wr, m2_v, m2_wr;
  logic [20:0] m1_a, m2_a;
  logic [3:0]  m1_bw, m2_bw;

  always #10 clk = ~clk;

  zbt_sram_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_bw_n(sram_bw_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_cs_n(sram_cs_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] peek(logic [20:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  function automatic logic [31:0] ref_peek(logic [20:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 32'h0;
  endfunction

  // SRAM model: command sampled one edge after its cycle, data slot in the next cycle
  always @(posedge clk) begin
    if (m2_v && m2_wr && sram_dq_oe)
      mem[int'(m2_a)] = merge(peek(m2_a), sram_dq_out, ~m2_bw);
    m2_v <= m1_v; m2_wr <= m1_wr; m2_a <= m1_a; m2_bw <= m1_bw;
    m1_v <= !sram_cs_n; m1_wr <= !sram_we_n; m1_a <= sram_addr; m1_bw <= sram_bw_n;
  end

  assign sram_dq_in = (m2_v && !m2_wr && !sram_oe_n) ? peek(m2_a) : 32'hBAD0_BAD0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins();
    chk(req_ready === 1'b1, "R8 ready", 64'(req_ready), 64'd1);
    chk(sram_we_n === !(h0.v && h0.wr), "R3 we_n", 64'(sram_we_n), 64'(!(h0.v && h0.wr)));
    chk(sram_bw_n === ((h0.v && h0.wr) ? ~h0.be : 4'hF), "R3 bw_n",
        64'(sram_bw_n), 64'((h0.v && h0.wr) ? ~h0.be : 4'hF));
    if (h0.v) chk(sram_addr === h0.a, "R2 addr", 64'(sram_addr), 64'(h0.a));
    chk(sram_cs_n === !(h0.v || (h1.v && !h1.wr) || (h2.v && !h2.wr)), "R6 cs_n",
        64'(sram_cs_n), 64'(!(h0.v || (h1.v && !h1.wr) || (h2.v && !h2.wr))));
    chk(sram_dq_oe === (h2.v && h2.wr), "R4 dq_oe", 64'(sram_dq_oe), 64'(h2.v && h2.wr));
    if (h2.v && h2.wr) chk(sram_dq_out === h2.wd, "R4 dq_out", 64'(sram_dq_out), 64'(h2.wd));
    chk(sram_oe_n === !(h2.v && !h2.wr), "R5 oe_n", 64'(sram_oe_n), 64'(!(h2.v && !h2.wr)));
    chk(rsp_valid === (h3.v && !h3.wr), "R7 rsp_valid", 64'(rsp_valid), 64'(h3.v && !h3.wr));
    if (h3.v && !h3.wr) chk(rsp_rdata === h3.ex, "R7 rsp_rdata", 64'(rsp_rdata), 64'(h3.ex));
  endtask

  task automatic step(bit v, bit wr, logic [20:0] wa, logic [31:0] wd, logic [3:0] be);
    op_t cur;
    req_valid = v; req_write = wr;
    req_addr = {wa, 2'($urandom_range(0, 3))};
    req_wdata = wd; req_be = be;
    cur = '0;
    if (v && req_ready) begin
      cur.v = 1'b1; cur.wr = wr; cur.a = wa; cur.wd = wd; cur.be = be;
      if (wr) ref_mem[int'(wa)] = merge(ref_peek(wa), wd, be);
      else    cur.ex = ref_peek(wa);
    end
    @(posedge clk);
    @(negedge clk);
    h3 = h2; h2 = h1; h1 = h0; h0 = cur;
    check_pins();
  endtask

  task automatic do_reset(int n);
    req_valid = 1'b0;
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(sram_cs_n === 1'b1 && sram_we_n === 1'b1 && sram_oe_n === 1'b1, "R1 strobes idle",
          64'({sram_cs_n, sram_we_n, sram_oe_n}), 64'h7);
      chk(sram_bw_n === 4'hF && sram_dq_oe === 1'b0, "R1 bw/dq_oe idle",
          64'({sram_bw_n, sram_dq_oe}), 64'h1E);
      chk(rsp_valid === 1'b0, "R9 no response in reset", 64'(rsp_valid), 64'd0);
      chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    end
    rst = 1'b0;
    h0 = '0; h1 = '0; h2 = '0; h3 = '0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    h0 = '0; h1 = '0; h2 = '0; h3 = '0;
    m1_v = 0; m2_v = 0; m1_wr = 0; m2_wr = 0; m1_a = '0; m2_a = '0; m1_bw = '1; m2_bw = '1;
    @(negedge clk);
    do_reset(3);
    step(0, 0, 21'd0, 32'd0, 4'h0);

    // R7: write then read of the same word on consecutive clocks
    step(1, 1, 21'h00_0005, 32'hCAFE_F00D, 4'hF);
    step(1, 0, 21'h00_0005, 32'd0, 4'h0);
    // R3: partial and empty byte enables
    step(1, 1, 21'h00_0005, 32'h1122_3344, 4'b0101);
    step(1, 1, 21'h00_0005, 32'hFFFF_FFFF, 4'b0000);
    step(1, 0, 21'h00_0005, 32'd0, 4'h0);
    // R8: alternating read/write every clock, high address bits set
    for (int i = 0; i < 12; i++)
      step(1, i[0], 21'h1F_FFF0 + 21'(i % 3), 32'hA500_0000 + 32'(i), 4'hF);
    for (int i = 0; i < 4; i++) step(0, 0, 21'd0, 32'd0, 4'h0);

    // R9: reset with reads and writes in flight
    step(1, 0, 21'h1F_FFF0, 32'd0, 4'h0);
    step(1, 1, 21'h00_0007, 32'h7777_7777, 4'hF);
    step(1, 0, 21'h1F_FFF1, 32'd0, 4'h0);
    do_reset(1);
    for (int i = 0; i < 4; i++) step(0, 0, 21'd0, 32'd0, 4'h0);
    ref_mem[int'(21'h00_0007)] = peek(21'h00_0007);

    for (int i = 0; i < 1500; i++) begin
      logic [20:0] wa;
      wa = {2'($urandom_range(0, 3)), 16'h0, 3'($urandom_range(0, 7))};
      step($urandom_range(0, 9) < 8, $urandom_range(0, 1) == 1, wa, $urandom(), 4'($urandom()));
    end
    for (int i = 0; i < 4; i++) step(0, 0, 21'd0, 32'd0, 4'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule